// File: doc/BRIEF.md
# Dual Half-Word Mailbox Registers

Two 32-bit message registers carry words between a host processor and a DSP. One register is directed to the host and the other to the DSP. Each side has its own register port with a 2-bit address, a write enable, a read enable, a 16-bit write bus and a 16-bit read bus. Through that port it reaches either mailbox one 16-bit half at a time. Bit 31 of each mailbox is a message-pending flag that sits inside the data word. The order of half-word accesses drives the handshake. The sender writes the high half first, which withdraws any pending flag. It then writes the low half, which publishes the message. The receiver may poll the high half as often as it likes. Reading the low half consumes the message.

Each flag also leaves the block as a level signal, which the receiving side can route to an interrupt input or poll. The block resolves accesses that both sides make in the same cycle. When a write and a read of the same mailbox coincide, the flag is never lost. When two writes to the same half coincide, the sending side wins.

Top module: `mbox_pair`

## Requirements
- R1: After reset both mailboxes hold zero, both pending outputs are low, and every read returns zero.
- R2: A high-half write loads bits 30:16 from write data bits 14:0, leaves bits 15:0 unchanged, and clears bit 31 whatever write data bit 15 holds.
- R3: A low-half write loads bits 15:0, leaves bits 30:16 unchanged, and sets bit 31.
- R4: A low-half read returns bits 15:0 combinationally in the same cycle, from the value held before the access. At the next clock edge it clears bit 31 and leaves every other bit unchanged.
- R5: A high-half read returns bits 31:16, pending flag included, and changes nothing.
- R6: The address map is the same for both sides: 0 is the to-host high half, 1 is the to-host low half, 2 is the to-DSP high half and 3 is the to-DSP low half. An access to one mailbox never changes the other.
- R7: When a low-half write and a flag-clearing access (a high-half write or a low-half read, from either side) hit the same mailbox in the same cycle, bit 31 ends up set.
- R8: When both sides write the same half of a mailbox in the same cycle, the sending side's data is stored. The DSP sends to the to-host mailbox and the host sends to the to-DSP mailbox.
- R9: to_host_pend_o and to_dsp_pend_o equal bit 31 of their mailboxes and change only at clock edges.
- R10: A side's read bus is zero in any cycle in which its read enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| host_addr_i | input | 2 | Host register select |
| host_we_i | input | 1 | Host write enable |
| host_re_i | input | 1 | Host read enable |
| host_wdata_i | input | 16 | Host write data |
| host_rdata_o | output | 16 | Host read data (combinational) |
| dsp_addr_i | input | 2 | DSP register select |
| dsp_we_i | input | 1 | DSP write enable |
| dsp_re_i | input | 1 | DSP read enable |
| dsp_wdata_i | input | 16 | DSP write data |
| dsp_rdata_o | output | 16 | DSP read data (combinational) |
| to_host_pend_o | output | 1 | Bit 31 of the to-host mailbox |
| to_dsp_pend_o | output | 1 | Bit 31 of the to-DSP mailbox |

## Verification
The bench sweeps every pairing of host and DSP operations over all four offsets: idle, write, read, and write with read, with data that changes from step to step. This covers same-cycle collisions. If set and clear were ranked the wrong way, a message written during a consuming read would vanish. If the wrong side won a write collision, the stored half would hold the receiver's value. The bench also checks that a low-half read returns the value from before the edge, so a design that clears first or reads a cycle late returns wrong data. Finally, a high-half write with bit 15 set must still clear the flag, so a design that stores the raw bit would leave a stale pending flag.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  localparam int ADDR_W     = 2;
  localparam int SIDE_HOST  = 0;
  localparam int SIDE_DSP   = 1;
  localparam int MB_TO_HOST = 0;
  localparam int MB_TO_DSP  = 1;
  localparam int N_MB       = 2;
  localparam int N_SIDE     = 2;
endpackage

// File: rtl/mbox_cell.sv
module mbox_cell #(
  parameter int HALF_W = 16,
  parameter int SENDER = 0
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [1:0]                    we_hi_i,
  input  logic [1:0]                    we_lo_i,
  input  logic [1:0]                    rd_lo_i,
  input  logic [1:0][HALF_W-1:0]        wdata_i,
  output logic [2*HALF_W-1:0]           word_o
);
  localparam int WORD_W = 2 * HALF_W;
  localparam int RCV    = 1 - SENDER;

  logic [WORD_W-1:0] word_q, word_d;
  logic [HALF_W-2:0] hi_src;
  logic [HALF_W-1:0] lo_src;
  logic              set_flag, clr_flag;

  always_comb begin
    // sender wins same-half write collisions
    hi_src   = we_hi_i[SENDER] ? wdata_i[SENDER][HALF_W-2:0] : wdata_i[RCV][HALF_W-2:0];
    lo_src   = we_lo_i[SENDER] ? wdata_i[SENDER] : wdata_i[RCV];
    set_flag = |we_lo_i;
    clr_flag = (|we_hi_i) | (|rd_lo_i);
    word_d   = word_q;
    if (|we_hi_i) word_d[WORD_W-2:HALF_W] = hi_src;
    if (|we_lo_i) word_d[HALF_W-1:0]      = lo_src;
    // set beats clear so a new message is never dropped
    if (set_flag)      word_d[WORD_W-1] = 1'b1;
    else if (clr_flag) word_d[WORD_W-1] = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) word_q <= '0;
    else         word_q <= word_d;
  end

  assign word_o = word_q;
endmodule

// File: rtl/mbox_rd_port.sv
module mbox_rd_port
  import mbox_pkg::*;
#(
  parameter int HALF_W = 16
) (
  input  logic [ADDR_W-1:0]              addr_i,
  input  logic                           re_i,
  input  logic [N_MB-1:0][2*HALF_W-1:0]  words_i,
  output logic [HALF_W-1:0]              rdata_o
);
  logic [2*HALF_W-1:0] sel_word;

  always_comb begin
    sel_word = words_i[addr_i[1]];
    rdata_o  = '0;
    if (re_i) rdata_o = addr_i[0] ? sel_word[HALF_W-1:0] : sel_word[2*HALF_W-1:HALF_W];
  end
endmodule

// File: rtl/mbox_pair.sv
module mbox_pair
  import mbox_pkg::*;
#(
  parameter int HALF_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] host_addr_i,
  input  logic              host_we_i,
  input  logic              host_re_i,
  input  logic [HALF_W-1:0] host_wdata_i,
  output logic [HALF_W-1:0] host_rdata_o,
  input  logic [ADDR_W-1:0] dsp_addr_i,
  input  logic              dsp_we_i,
  input  logic              dsp_re_i,
  input  logic [HALF_W-1:0] dsp_wdata_i,
  output logic [HALF_W-1:0] dsp_rdata_o,
  output logic              to_host_pend_o,
  output logic              to_dsp_pend_o
);
  localparam int WORD_W = 2 * HALF_W;

  logic [N_SIDE-1:0][ADDR_W-1:0] addr;
  logic [N_SIDE-1:0]             we, re;
  logic [N_SIDE-1:0][HALF_W-1:0] wdata, rdata;
  logic [N_MB-1:0][WORD_W-1:0]   words;

  assign addr[SIDE_HOST]  = host_addr_i;
  assign addr[SIDE_DSP]   = dsp_addr_i;
  assign we[SIDE_HOST]    = host_we_i;
  assign we[SIDE_DSP]     = dsp_we_i;
  assign re[SIDE_HOST]    = host_re_i;
  assign re[SIDE_DSP]     = dsp_re_i;
  assign wdata[SIDE_HOST] = host_wdata_i;
  assign wdata[SIDE_DSP]  = dsp_wdata_i;

  for (genvar m = 0; m < N_MB; m++) begin : g_mb
    logic [N_SIDE-1:0] we_hi, we_lo, rd_lo;
    for (genvar s = 0; s < N_SIDE; s++) begin : g_dec
      logic hit;
      assign hit      = (addr[s][1] == 1'(m));
      assign we_hi[s] = we[s] & hit & ~addr[s][0];
      assign we_lo[s] = we[s] & hit &  addr[s][0];
      assign rd_lo[s] = re[s] & hit &  addr[s][0];
    end
    mbox_cell #(
      .HALF_W (HALF_W),
      .SENDER ((m == MB_TO_HOST) ? SIDE_DSP : SIDE_HOST)
    ) u_cell (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .we_hi_i (we_hi),
      .we_lo_i (we_lo),
      .rd_lo_i (rd_lo),
      .wdata_i (wdata),
      .word_o  (words[m])
    );
  end

  for (genvar s = 0; s < N_SIDE; s++) begin : g_rd
    mbox_rd_port #(.HALF_W(HALF_W)) u_rd (
      .addr_i  (addr[s]),
      .re_i    (re[s]),
      .words_i (words),
      .rdata_o (rdata[s])
    );
  end

  assign host_rdata_o   = rdata[SIDE_HOST];
  assign dsp_rdata_o    = rdata[SIDE_DSP];
  assign to_host_pend_o = words[MB_TO_HOST][WORD_W-1];
  assign to_dsp_pend_o  = words[MB_TO_DSP][WORD_W-1];
endmodule

// File: rtl/mbox_pair_chk.sv
module mbox_pair_chk #(
  parameter int HALF_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [1:0]        host_addr_i,
  input logic              host_we_i,
  input logic              host_re_i,
  input logic [HALF_W-1:0] host_rdata_o,
  input logic [1:0]        dsp_addr_i,
  input logic              dsp_we_i,
  input logic              dsp_re_i,
  input logic [HALF_W-1:0] dsp_rdata_o,
  input logic              to_host_pend_o,
  input logic              to_dsp_pend_o
);
  logic hw_h, lw_h, lr_h, hw_d, lw_d, lr_d;
  assign hw_h = (host_we_i && host_addr_i == 2'd0) || (dsp_we_i && dsp_addr_i == 2'd0);
  assign lw_h = (host_we_i && host_addr_i == 2'd1) || (dsp_we_i && dsp_addr_i == 2'd1);
  assign lr_h = (host_re_i && host_addr_i == 2'd1) || (dsp_re_i && dsp_addr_i == 2'd1);
  assign hw_d = (host_we_i && host_addr_i == 2'd2) || (dsp_we_i && dsp_addr_i == 2'd2);
  assign lw_d = (host_we_i && host_addr_i == 2'd3) || (dsp_we_i && dsp_addr_i == 2'd3);
  assign lr_d = (host_re_i && host_addr_i == 2'd3) || (dsp_re_i && dsp_addr_i == 2'd3);

  a_r3_lo_wr_sets_host: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lw_h |=> to_host_pend_o);
  a_r3_lo_wr_sets_dsp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lw_d |=> to_dsp_pend_o);
  a_r7_set_wins_host: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lw_h && (hw_h || lr_h)) |=> to_host_pend_o);
  a_r2_hi_wr_clears_host: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hw_h && !lw_h) |=> !to_host_pend_o);
  a_r2_hi_wr_clears_dsp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hw_d && !lw_d) |=> !to_dsp_pend_o);
  a_r4_lo_rd_clears_host: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lr_h && !lw_h) |=> !to_host_pend_o);
  a_r4_lo_rd_clears_dsp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lr_d && !lw_d) |=> !to_dsp_pend_o);
  // R5, R6: high reads and other-mailbox traffic leave the flag alone
  a_r6_untouched_host: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(hw_h || lw_h || lr_h) |=> $stable(to_host_pend_o));
  a_r6_untouched_dsp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(hw_d || lw_d || lr_d) |=> $stable(to_dsp_pend_o));
  a_r10_idle_rd_host: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !host_re_i |-> host_rdata_o == '0);
  a_r10_idle_rd_dsp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dsp_re_i |-> dsp_rdata_o == '0);
endmodule

bind mbox_pair mbox_pair_chk #(.HALF_W(HALF_W)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .host_addr_i    (host_addr_i),
  .host_we_i      (host_we_i),
  .host_re_i      (host_re_i),
  .host_rdata_o   (host_rdata_o),
  .dsp_addr_i     (dsp_addr_i),
  .dsp_we_i       (dsp_we_i),
  .dsp_re_i       (dsp_re_i),
  .dsp_rdata_o    (dsp_rdata_o),
  .to_host_pend_o (to_host_pend_o),
  .to_dsp_pend_o  (to_dsp_pend_o)
);

// File: tb/mbox_pair_tb.sv
`timescale 1ns/1ps
module mbox_pair_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [1:0]  host_addr_i = '0, dsp_addr_i = '0;
  logic        host_we_i = 1'b0, host_re_i = 1'b0, dsp_we_i = 1'b0, dsp_re_i = 1'b0;
  logic [15:0] host_wdata_i = '0, dsp_wdata_i = '0;
  logic [15:0] host_rdata_o, dsp_rdata_o;
  logic        to_host_pend_o, to_dsp_pend_o;

  int n_chk = 0, n_fail = 0;
  logic [31:0] mdl [2];

  always #10 clk_i = ~clk_i;

  mbox_pair u_dut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // side 0 = host, 1 = dsp; mailbox 0 = to-host (dsp sends), 1 = to-dsp (host sends)
  task automatic step(input logic [1:0] ha, input logic hw, input logic hr, input logic [15:0] hd,
                      input logic [1:0] da, input logic dw, input logic dr, input logic [15:0] dd);
    logic [31:0] nx [2];
    @(negedge clk_i);
    chk("R9 to_host_pend", 32'(to_host_pend_o), 32'(mdl[0][31]));
    chk("R9 to_dsp_pend",  32'(to_dsp_pend_o),  32'(mdl[1][31]));
    host_addr_i = ha; host_we_i = hw; host_re_i = hr; host_wdata_i = hd;
    dsp_addr_i = da;  dsp_we_i = dw;  dsp_re_i = dr;  dsp_wdata_i = dd;
    #5;
    if (!hr) chk("R10 host idle rdata", 32'(host_rdata_o), 0);
    else if (ha[0]) chk("R4 host low read", 32'(host_rdata_o), 32'(mdl[ha[1]][15:0]));
    else chk("R5 host high read", 32'(host_rdata_o), 32'(mdl[ha[1]][31:16]));
    if (!dr) chk("R10 dsp idle rdata", 32'(dsp_rdata_o), 0);
    else if (da[0]) chk("R4 dsp low read", 32'(dsp_rdata_o), 32'(mdl[da[1]][15:0]));
    else chk("R5 dsp high read", 32'(dsp_rdata_o), 32'(mdl[da[1]][31:16]));
    for (int m = 0; m < 2; m++) begin
      logic h_hi, h_lo, d_hi, d_lo, rd_lo;
      h_hi = hw && ha == 2'(2*m);   h_lo = hw && ha == 2'(2*m+1);
      d_hi = dw && da == 2'(2*m);   d_lo = dw && da == 2'(2*m+1);
      rd_lo = (hr && ha == 2'(2*m+1)) || (dr && da == 2'(2*m+1));
      nx[m] = mdl[m];
      // R8: sender priority
      if (m == 0) begin
        if (d_hi) nx[m][30:16] = dd[14:0]; else if (h_hi) nx[m][30:16] = hd[14:0];
        if (d_lo) nx[m][15:0] = dd;        else if (h_lo) nx[m][15:0] = hd;
      end else begin
        if (h_hi) nx[m][30:16] = hd[14:0]; else if (d_hi) nx[m][30:16] = dd[14:0];
        if (h_lo) nx[m][15:0] = hd;        else if (d_lo) nx[m][15:0] = dd;
      end
      // R2 R3 R4 R7
      if (h_lo || d_lo) nx[m][31] = 1'b1;
      else if (h_hi || d_hi || rd_lo) nx[m][31] = 1'b0;
    end
    @(posedge clk_i);
    mdl[0] = nx[0]; mdl[1] = nx[1];
    #1;
    host_we_i = 0; host_re_i = 0; dsp_we_i = 0; dsp_re_i = 0;
  endtask

  task automatic peek(input int m, output logic [31:0] w);
    // read high half only (no side effect) and low half via model-free path
    @(negedge clk_i);
    host_addr_i = 2'(2*m); host_re_i = 1; host_we_i = 0;
    #5 w[31:16] = host_rdata_o;
    host_addr_i = 2'(2*m+1);
    #1 w[15:0] = host_rdata_o;
    host_re_i = 0;
  endtask

  initial begin
    #(20 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] w;
    mdl[0] = '0; mdl[1] = '0;
    #35;
    chk("R1 reset to_host_pend", 32'(to_host_pend_o), 0);
    chk("R1 reset to_dsp_pend", 32'(to_dsp_pend_o), 0);
    rst_ni = 1'b1;
    peek(0, w); chk("R1 reset to-host word", w, 0);
    peek(1, w); chk("R1 reset to-dsp word", w, 0);

    // directed handshake: DSP sends to host; hi write with bit15 set must clear flag
    step(2'd0, 0, 0, 0, 2'd1, 1, 0, 16'h1234);
    chk("R3 low write publishes", 32'(to_host_pend_o), 1);
    step(2'd0, 0, 0, 0, 2'd0, 1, 0, 16'hFFFF);
    chk("R2 high write clears flag", 32'(to_host_pend_o), 0);
    peek(0, w); chk("R2 high write keeps low half", w, 32'h7FFF_1234);
    chk("R6 other mailbox untouched", 32'(to_dsp_pend_o), 0);
    step(2'd0, 0, 0, 0, 2'd1, 1, 0, 16'hBEEF);
    step(2'd0, 0, 1, 0, 2'd0, 0, 0, 0);
    chk("R5 high read keeps flag", 32'(to_host_pend_o), 1);
    step(2'd1, 0, 1, 0, 2'd0, 0, 0, 0);
    chk("R4 low read clears flag", 32'(to_host_pend_o), 0);
    // R7: host consumes while DSP publishes
    step(2'd1, 0, 1, 0, 2'd1, 1, 0, 16'h0A0A);
    chk("R7 set wins over read clear", 32'(to_host_pend_o), 1);
    // R8: both write low half of to-dsp mailbox
    step(2'd3, 1, 0, 16'h1111, 2'd3, 1, 0, 16'h2222);
    peek(1, w); chk("R8 host wins to-dsp collision", 32'(w[15:0]), 32'h1111);

    // sweep every op pair, several data rounds
    for (int rnd = 0; rnd < 4; rnd++)
      for (int ho = 0; ho < 13; ho++)
        for (int d_o = 0; d_o < 13; d_o++) begin
          logic [15:0] hd, dd;
          hd = 16'((rnd * 16'h9E37) ^ (ho * 16'h3C5B) ^ (d_o * 16'h0101));
          dd = 16'((rnd * 16'h7F4A) ^ (ho * 16'h1357) ^ (d_o * 16'hA5C3) ^ 16'h8000);
          step(ho == 0 ? 2'd0 : 2'((ho - 1) / 3), ho != 0 && (ho - 1) % 3 != 1,
               ho != 0 && (ho - 1) % 3 != 0, hd,
               d_o == 0 ? 2'd0 : 2'((d_o - 1) / 3), d_o != 0 && (d_o - 1) % 3 != 1,
               d_o != 0 && (d_o - 1) % 3 != 0, dd);
        end
    step(2'd0, 0, 0, 0, 2'd0, 0, 0, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule